// File: doc/BRIEF.md
# Half-bridge PWM timer with mid-period reload

This block is one PWM timer channel pair that drives a single half-bridge of a stepper-motor chopper. A signed counter steps from a programmable start value up to a modulo value and then starts again. Two compare values place the turn-on and turn-off instants of output A. Output B is either the complement of A or is driven by its own pair of compare values.

Every timing value is double-buffered. Firmware writes a shadow copy and then arms a load-enable flag. The shadow copies move into the active set at the next reload event, and the flag then clears itself. The end of each period always gives a reload event. When the mid-period option is on, the cycle in which the counter equals a programmable half value gives a second one. Each event also produces its own interrupt pulse. Firmware can therefore reshape the duty cycle twice per period, which yields the on / slow-decay / on / slow-decay chopping pattern with the lowest current ripple.

The control word picks several things: where counter restarts come from, where reload events come from, and which of eight sources forces the outputs to a preset level.

Top module: `pwm_sub`

## Requirements
- R1: While run is high, the counter steps by one per cycle from the active start value up to the active modulo value, compared as signed numbers. In the cycle after it holds a value at or above the modulo value, it holds the start value. A period therefore lasts modulo minus start plus one cycles. `full_irq_o` is high in exactly one cycle of each period: the cycle in which the counter is at or above the modulo value.
- R2: Output A goes high in the cycle after the counter equals the active A-on value. It goes low in the cycle after the counter equals the active A-off value. This gives off minus on high cycles per period.
- R3: When the active A-off value is less than or equal to the A-on value, A never rises through a compare and stays low.
- R4: Write addresses are 0 start, 1 half value, 2 modulo, 3 A-on, 4 A-off, 5 control, 6 B-on and 7 B-off. A write to any address except 5 lands only in a shadow copy. A one-cycle `ldok_set_i` pulse raises `ldok_o` in the next cycle. A reload event with `ldok_o` high copies all shadows into the active set and clears `ldok_o`. With `ldok_o` low, reload events change nothing. The control word (address 5) takes effect in the cycle after its write.
- R5: Control bit 11 enables the mid-period reload. When it is set, the cycle in which the counter equals the active half value is also a reload event, and `half_irq_o` is high in that cycle. When it is clear, `half_irq_o` stays low.
- R6: Control bit 2 chooses the reload source: 0 selects the block's own end-of-period and mid-period events, and 1 selects only `master_reload_i`.
- R7: Control bits 9:8 choose an extra counter-restart source: 00 selects none (only the counter's own wrap), 01 selects `master_reload_i`, 10 selects `master_sync_i` and 11 selects `ext_sync_i`. A pulse on the selected input makes the counter hold the start value in the next cycle. Unselected inputs have no effect.
- R8: Control bit 7 enables forcing. Bits 5:3 choose the force source: 000 `local_force_i`, 001 `master_force_i`, 010 own reload event, 011 `master_reload_i`, 100 own wrap, 101 `master_sync_i`, 110 `ext_force_i`, 111 `ext_sync_i`. On the selected event both channel states take the level of bit 12 in the next cycle and keep it until their next compare edge.
- R9: With control bit 13 clear, B is the inverse of A. With it set, B follows R2 using the B-on and B-off values.
- R10: While run is low, the counter, the output states and the active values hold, both interrupts stay low, and no transfer happens.
- R11: During reset, A is low, B is high, both interrupts are low, `ldok_o` is low, and all shadow, active and control values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | CNT_W | Write data |
| ldok_set_i | input | 1 | Arms the shadow-to-active transfer |
| run_i | input | 1 | Counter enable |
| local_force_i | input | 1 | Local software force strobe |
| master_force_i | input | 1 | Force strobe from a master channel |
| master_reload_i | input | 1 | Reload strobe from a master channel |
| master_sync_i | input | 1 | Sync strobe from a master channel |
| ext_force_i | input | 1 | External force strobe |
| ext_sync_i | input | 1 | External sync strobe |
| pwm_a_o | output | 1 | Channel A output |
| pwm_b_o | output | 1 | Channel B output |
| full_irq_o | output | 1 | End-of-period reload pulse |
| half_irq_o | output | 1 | Mid-period reload pulse |
| ldok_o | output | 1 | Transfer armed |

## Verification
The interrupts follow the counter in the same cycle. The outputs change one cycle after the counter value that causes them. A counter restart shows up one cycle after the strobe, and `ldok_o` changes one cycle after its pulse or its reload. The bench drives and samples on falling edges and measures every result as an offset from the cycle in which `full_irq_o` was seen. Taking the counter to be at start plus j minus 1, j cycles after that sample, it expects output A at offset k to reflect the counter value at offset k−1. Duty cycles are counted over exactly one period, so a single cycle of misplacement changes the count.

// File: rtl/pwm_sub_pkg.sv
package pwm_sub_pkg;
  localparam int CTRL_W   = 16;
  localparam int NSLOT    = 7;
  localparam int S_INIT   = 0;
  localparam int S_HALF   = 1;
  localparam int S_MOD    = 2;
  localparam int S_A_ON   = 3;
  localparam int S_A_OFF  = 4;
  localparam int S_B_ON   = 5;
  localparam int S_B_OFF  = 6;
  localparam logic [2:0] A_CTRL = 3'd5;

  localparam int CB_INDEP = 13;
  localparam int CB_FLVL  = 12;
  localparam int CB_HALF  = 11;
  localparam int CB_ISEL  = 8;
  localparam int CB_FEN   = 7;
  localparam int CB_FSEL  = 3;
  localparam int CB_RSEL  = 2;

  typedef enum logic [1:0] {
    IS_LOCAL, IS_MST_RELOAD, IS_MST_SYNC, IS_EXT_SYNC
  } init_src_e;

  typedef enum logic [2:0] {
    FS_LOC_FORCE, FS_MST_FORCE, FS_LOC_RELOAD, FS_MST_RELOAD,
    FS_LOC_SYNC, FS_MST_SYNC, FS_EXT_FORCE, FS_EXT_SYNC
  } frc_src_e;

  typedef struct packed {
    logic      indep;
    logic      frc_lvl;
    logic      half_en;
    init_src_e init_sel;
    logic      frc_en;
    frc_src_e  frc_sel;
    logic      rld_sel;
  } ctrl_t;

  // slot index -> write address (address 5 is the control word)
  function automatic logic [2:0] slot_addr(input int s);
    return (s < 5) ? 3'(s) : 3'(s + 1);
  endfunction

  function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] d);
    ctrl_t c;
    c.indep    = d[CB_INDEP];
    c.frc_lvl  = d[CB_FLVL];
    c.half_en  = d[CB_HALF];
    c.init_sel = init_src_e'(d[CB_ISEL +: 2]);
    c.frc_en   = d[CB_FEN];
    c.frc_sel  = frc_src_e'(d[CB_FSEL +: 3]);
    c.rld_sel  = d[CB_RSEL];
    return c;
  endfunction
endpackage

// File: rtl/pwm_sub_regs.sv
module pwm_sub_regs
  import pwm_sub_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [2:0]              wr_addr_i,
  input  logic [CNT_W-1:0]        wr_data_i,
  input  logic                    ldok_set_i,
  input  logic                    rld_evt_i,
  output logic                    ldok_o,
  output ctrl_t                   ctrl_o,
  output logic signed [CNT_W-1:0] act_o [NSLOT]
);
  logic signed [CNT_W-1:0] shd [NSLOT];
  logic xfer;

  assign xfer = rld_evt_i & ldok_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSLOT; s++) begin
        shd[s]   <= '0;
        act_o[s] <= '0;
      end
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (wr_en_i && wr_addr_i == slot_addr(s)) shd[s] <= wr_data_i;
        if (xfer) act_o[s] <= shd[s];
      end
    end
  end

  // set wins over the self-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ldok_o <= 1'b0;
    else if (ldok_set_i) ldok_o <= 1'b1;
    else if (xfer)       ldok_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= '0;
    else if (wr_en_i && wr_addr_i == A_CTRL)
      ctrl_o <= decode_ctrl(CTRL_W'(wr_data_i));
  end
endmodule

// File: rtl/pwm_sub_counter.sv
module pwm_sub_counter
  import pwm_sub_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic signed [CNT_W-1:0] init_v_i,
  input  logic signed [CNT_W-1:0] mod_v_i,
  input  logic signed [CNT_W-1:0] half_v_i,
  input  logic                    half_en_i,
  input  init_src_e               init_sel_i,
  input  logic                    master_reload_i,
  input  logic                    master_sync_i,
  input  logic                    ext_sync_i,
  output logic signed [CNT_W-1:0] cnt_o,
  output logic                    full_evt_o,
  output logic                    half_evt_o
);
  logic ext_init;

  always_comb begin
    unique case (init_sel_i)
      IS_MST_RELOAD: ext_init = master_reload_i;
      IS_MST_SYNC:   ext_init = master_sync_i;
      IS_EXT_SYNC:   ext_init = ext_sync_i;
      default:       ext_init = 1'b0;
    endcase
  end

  // >= keeps the wrap safe after the modulo shrinks below the count
  assign full_evt_o = run_i & (cnt_o >= mod_v_i);
  assign half_evt_o = run_i & half_en_i & (cnt_o == half_v_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (run_i) begin
      if (ext_init || full_evt_o)  cnt_o <= init_v_i;
      else                         cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_sub_edge.sv
module pwm_sub_edge #(
  parameter int CNT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic signed [CNT_W-1:0] cnt_i,
  input  logic signed [CNT_W-1:0] on_v_i,
  input  logic signed [CNT_W-1:0] off_v_i,
  input  logic                    frc_i,
  input  logic                    frc_lvl_i,
  output logic                    out_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 out_o <= 1'b0;
    else if (run_i) begin
      if (frc_i)                                 out_o <= frc_lvl_i;
      else if (cnt_i == off_v_i)                 out_o <= 1'b0;
      else if (cnt_i == on_v_i && off_v_i > on_v_i) out_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_sub.sv
module pwm_sub
  import pwm_sub_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             ldok_set_i,
  input  logic             run_i,
  input  logic             local_force_i,
  input  logic             master_force_i,
  input  logic             master_reload_i,
  input  logic             master_sync_i,
  input  logic             ext_force_i,
  input  logic             ext_sync_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o,
  output logic             full_irq_o,
  output logic             half_irq_o,
  output logic             ldok_o
);
  localparam int NCH = 2;

  logic signed [CNT_W-1:0] act [NSLOT];
  logic signed [CNT_W-1:0] cnt, act_init;
  logic signed [CNT_W-1:0] on_v [NCH];
  logic signed [CNT_W-1:0] off_v [NCH];
  ctrl_t      ctrl;
  logic       full_evt, half_evt, rld_evt, frc_src, frc_evt;
  logic [NCH-1:0] ch_out;

  assign rld_evt  = ctrl.rld_sel ? (run_i & master_reload_i) : (full_evt | half_evt);
  assign act_init = act[S_INIT];

  pwm_sub_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .ldok_set_i,
    .rld_evt_i(rld_evt), .ldok_o, .ctrl_o(ctrl), .act_o(act)
  );

  pwm_sub_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i,
    .init_v_i(act_init), .mod_v_i(act[S_MOD]), .half_v_i(act[S_HALF]),
    .half_en_i(ctrl.half_en), .init_sel_i(ctrl.init_sel),
    .master_reload_i, .master_sync_i, .ext_sync_i,
    .cnt_o(cnt), .full_evt_o(full_evt), .half_evt_o(half_evt)
  );

  always_comb begin
    unique case (ctrl.frc_sel)
      FS_LOC_FORCE:  frc_src = local_force_i;
      FS_MST_FORCE:  frc_src = master_force_i;
      FS_LOC_RELOAD: frc_src = full_evt | half_evt;
      FS_MST_RELOAD: frc_src = master_reload_i;
      FS_LOC_SYNC:   frc_src = full_evt;
      FS_MST_SYNC:   frc_src = master_sync_i;
      FS_EXT_FORCE:  frc_src = ext_force_i;
      default:       frc_src = ext_sync_i;
    endcase
  end
  assign frc_evt = run_i & ctrl.frc_en & frc_src;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign on_v[ch]  = act[S_A_ON  + 2*ch];
    assign off_v[ch] = act[S_A_OFF + 2*ch];
    pwm_sub_edge #(.CNT_W(CNT_W)) u_edge (
      .clk_i, .rst_ni, .run_i, .cnt_i(cnt),
      .on_v_i(on_v[ch]), .off_v_i(off_v[ch]),
      .frc_i(frc_evt), .frc_lvl_i(ctrl.frc_lvl), .out_o(ch_out[ch])
    );
  end

  assign pwm_a_o    = ch_out[0];
  assign pwm_b_o    = ctrl.indep ? ch_out[1] : ~ch_out[0];
  assign full_irq_o = full_evt;
  assign half_irq_o = half_evt;
endmodule

// File: rtl/pwm_sub_chk.sv
module pwm_sub_chk #(
  parameter int CNT_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    run_i,
  input logic                    ldok_set_i,
  input logic                    pwm_a_o,
  input logic                    full_irq_o,
  input logic                    half_irq_o,
  input logic                    ldok_o,
  input logic signed [CNT_W-1:0] cnt_i,
  input logic signed [CNT_W-1:0] act_init_i,
  input logic signed [CNT_W-1:0] on_a_i,
  input logic signed [CNT_W-1:0] off_a_i,
  input logic                    frc_i,
  input logic                    rld_sel_i,
  input logic [1:0]              init_sel_i
);
  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_irq_o && init_sel_i == 2'b00 |=> cnt_i == $past(act_init_i));

  a_r2_rise_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_a_o) |-> $past(frc_i) || $past(cnt_i == on_a_i));

  a_r3_no_rise_degenerate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_a_o) |-> $past(frc_i) || $past(off_a_i > on_a_i));

  a_r4_ldok_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldok_o && full_irq_o && !rld_sel_i && !ldok_set_i |=> !ldok_o);

  a_r10_run_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_i) && $stable(pwm_a_o));

  a_r10_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !full_irq_o && !half_irq_o);
endmodule

bind pwm_sub pwm_sub_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .ldok_set_i(ldok_set_i),
  .pwm_a_o(pwm_a_o), .full_irq_o(full_irq_o), .half_irq_o(half_irq_o),
  .ldok_o(ldok_o), .cnt_i(cnt), .act_init_i(act_init),
  .on_a_i(on_v[0]), .off_a_i(off_v[0]), .frc_i(frc_evt),
  .rld_sel_i(ctrl.rld_sel), .init_sel_i(ctrl.init_sel)
);

// File: tb/pwm_sub_test.sv
module pwm_sub_test;
  localparam int W = 16;
  localparam int NV = 6;
  // start, modulo, on, off, expected high cycles per period
  localparam int VEC [NV][5] = '{
    '{-10,  9,  -5,  5, 10},
    '{  0, 19,   3, 15, 12},
    '{ -8,  7,   0,  1,  1},
    '{  0, 15,  10,  4,  0},
    '{  0, 15,   6,  6,  0},
    '{-20, 19, -20, 19, 39}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, wr_en, ldok_set, run, lfrc, mfrc, mrld, msync, efrc, esync;
  logic [2:0] wr_addr;
  logic [W-1:0] wr_data;
  logic pwm_a, pwm_b, full_irq, half_irq, ldok;
  int checks = 0, fails = 0;

  pwm_sub #(.CNT_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ldok_set_i(ldok_set), .run_i(run),
    .local_force_i(lfrc), .master_force_i(mfrc), .master_reload_i(mrld),
    .master_sync_i(msync), .ext_force_i(efrc), .ext_sync_i(esync),
    .pwm_a_o(pwm_a), .pwm_b_o(pwm_b), .full_irq_o(full_irq),
    .half_irq_o(half_irq), .ldok_o(ldok)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input int v);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(v);
    step();
    wr_en = 1'b0;
  endtask

  task automatic pulse_ldok();
    ldok_set = 1'b1; step(); ldok_set = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; wr_addr = '0; wr_data = '0; ldok_set = 0; run = 0;
    lfrc = 0; mfrc = 0; mrld = 0; msync = 0; efrc = 0; esync = 0;
    repeat (2) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic setup(input int ini, input int md, input int hv, input int aon,
                       input int aoff, input int bon, input int boff, input int ctl);
    wr(3'd0, ini); wr(3'd1, hv); wr(3'd2, md); wr(3'd3, aon); wr(3'd4, aoff);
    wr(3'd6, bon); wr(3'd7, boff); wr(3'd5, ctl);
    pulse_ldok();
    run = 1'b1;
    repeat (3 * (md - ini + 1) + 4) step();
  endtask

  task automatic wait_full();
    int g = 0;
    while (!full_irq && g < 1000) begin step(); g++; end
    if (g >= 1000) chk("R1 wait_full timeout", 1, 0);
  endtask

  task automatic steps_to_full(output int k);
    k = 0;
    do begin step(); k++; end while (!full_irq && k < 1000);
  endtask

  // call in the cycle full_irq is seen; covers one period of output cycles
  task automatic measure(input int n, input bit arm, output int hi_a, output int hi_b,
                         output int nfull, output int nhalf, output int same);
    hi_a = 0; hi_b = 0; nfull = 0; nhalf = 0; same = 0;
    if (arm) ldok_set = 1'b1;
    for (int k = 1; k <= n + 1; k++) begin
      step();
      ldok_set = 1'b0;
      if (k <= n) begin nfull += int'(full_irq); nhalf += int'(half_irq); end
      if (k >= 2) begin
        hi_a += int'(pwm_a); hi_b += int'(pwm_b); same += int'(pwm_a == pwm_b);
      end
    end
  endtask

  initial begin
    int ha, hb, nf, nh, sm, k, n, chg, irqs;
    logic a0;
    rst_n = 1'b0; wr_en = 0; wr_addr = '0; wr_data = '0; ldok_set = 0; run = 0;
    lfrc = 0; mfrc = 0; mrld = 0; msync = 0; efrc = 0; esync = 0;
    step();
    chk("R11 reset pwm_a", int'(pwm_a), 0);
    chk("R11 reset pwm_b", int'(pwm_b), 1);
    chk("R11 reset irqs", int'(full_irq) + int'(half_irq), 0);
    chk("R11 reset ldok", int'(ldok), 0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      setup(VEC[v][0], VEC[v][1], 0, VEC[v][2], VEC[v][3], 0, 0, 0);
      n = VEC[v][1] - VEC[v][0] + 1;
      wait_full();
      measure(n, 1'b0, ha, hb, nf, nh, sm);
      chk($sformatf("R2 R3 vec%0d high cycles", v), ha, VEC[v][4]);
      chk($sformatf("R1 vec%0d full irqs per period", v), nf, 1);
      chk($sformatf("R5 vec%0d half irqs when disabled", v), nh, 0);
      chk($sformatf("R9 vec%0d complement mismatches", v), sm, 0);
    end

    // R1 period and R2 edge offsets
    do_reset();
    setup(-4, 11, 0, 0, 8, 0, 0, 0);
    wait_full();
    steps_to_full(k);
    chk("R1 period length", k, 16);
    k = 0;
    do begin step(); k++; end while (!pwm_a && k < 100);
    chk("R2 rise offset", k, 6);
    do begin step(); k++; end while (pwm_a && k < 100);
    chk("R2 fall offset", k, 14);

    // R4 shadow gating and ldok self-clear
    chk("R4 ldok clear after transfer", int'(ldok), 0);
    wr(3'd4, 2);
    repeat (48) step();
    wait_full();
    measure(16, 1'b0, ha, hb, nf, nh, sm);
    chk("R4 shadow write without ldok ignored", ha, 8);
    pulse_ldok();
    chk("R4 ldok raised", int'(ldok), 1);
    wait_full();
    measure(16, 1'b0, ha, hb, nf, nh, sm);
    chk("R4 new duty after reload", ha, 2);
    chk("R4 ldok cleared", int'(ldok), 0);

    // R5 mid-period reload
    do_reset();
    setup(0, 19, 10, 12, 14, 0, 0, 1 << 11);
    wait_full();
    measure(20, 1'b0, ha, hb, nf, nh, sm);
    chk("R5 base duty", ha, 2);
    chk("R5 half irqs per period", nh, 1);
    wr(3'd4, 18);
    wait_full();
    measure(20, 1'b1, ha, hb, nf, nh, sm);
    chk("R5 duty changed at half point", ha, 6);
    chk("R5 ldok cleared by half reload", int'(ldok), 0);

    // R6 master reload source
    do_reset();
    setup(0, 15, 0, 2, 10, 0, 0, 0);
    wr(3'd5, 1 << 2);
    wr(3'd4, 4);
    pulse_ldok();
    repeat (40) step();
    chk("R6 local events no transfer ldok", int'(ldok), 1);
    wait_full();
    measure(16, 1'b0, ha, hb, nf, nh, sm);
    chk("R6 duty unchanged", ha, 8);
    mrld = 1'b1; step(); mrld = 1'b0;
    chk("R6 master reload clears ldok", int'(ldok), 0);
    repeat (40) step();
    wait_full();
    measure(16, 1'b0, ha, hb, nf, nh, sm);
    chk("R6 duty after master reload", ha, 2);

    // R7 counter restart source = master sync (bits 9:8 = 10)
    do_reset();
    setup(0, 15, 0, 2, 10, 0, 0, 2 << 8);
    wait_full();
    repeat (3) step();
    esync = 1'b1; step(); esync = 1'b0;
    steps_to_full(k);
    chk("R7 unselected ext sync ignored", k, 12);
    repeat (3) step();
    msync = 1'b1; step(); msync = 1'b0;
    steps_to_full(k);
    chk("R7 master sync restarts counter", k, 15);

    // R8 force
    do_reset();
    setup(0, 15, 0, 10, 4, 0, 0, 0);
    wr(3'd5, (1 << 12) | (1 << 7));
    chk("R8 degenerate output low before force", int'(pwm_a), 0);
    mfrc = 1'b1; step(); mfrc = 1'b0;
    chk("R8 unselected master force ignored", int'(pwm_a), 0);
    lfrc = 1'b1; step(); lfrc = 1'b0;
    chk("R8 local force sets level", int'(pwm_a), 1);
    wait_full();
    repeat (7) step();
    chk("R8 forced level released at off match", int'(pwm_a), 0);
    wr(3'd5, (1 << 12) | (1 << 7) | (4 << 3));
    wait_full();
    measure(16, 1'b0, ha, hb, nf, nh, sm);
    chk("R8 force on own wrap high cycles", ha, 5);

    // R9 independent B
    do_reset();
    setup(0, 15, 0, 2, 10, 5, 9, 1 << 13);
    wait_full();
    measure(16, 1'b0, ha, hb, nf, nh, sm);
    chk("R9 independent A duty", ha, 8);
    chk("R9 independent B duty", hb, 4);

    // R10 run low holds everything
    do_reset();
    setup(0, 15, 0, 2, 10, 0, 0, 0);
    repeat (5) step();
    run = 1'b0;
    step();
    a0 = pwm_a;
    wr(3'd4, 3);
    pulse_ldok();
    chg = 0; irqs = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      chg += int'(pwm_a != a0);
      irqs += int'(full_irq) + int'(half_irq);
    end
    chk("R10 output held while stopped", chg, 0);
    chk("R10 no irqs while stopped", irqs, 0);
    chk("R10 no transfer while stopped", int'(ldok), 1);
    run = 1'b1;
    repeat (20) step();
    wait_full();
    measure(16, 1'b0, ha, hb, nf, nh, sm);
    chk("R10 resumes and transfers", ha, 1);

    summary();
  end
endmodule